// File: doc/BRIEF.md
# 4x4 Luma Intra Predictor

This block computes the intra prediction for one 4x4 luma block in a single clock cycle. The caller presents the reconstructed neighbours: eight samples from the row above (four directly above and four above-right), four samples from the column to the left, and the corner sample above-left. It also presents one of nine prediction directions and three availability flags. A start handshake latches the sixteen predicted samples, which the block returns as four 32-bit row words.

Before predicting, the block checks that the requested direction is legal for the neighbours that are present. A request for an unknown direction code, or for a direction that reads neighbours flagged as missing, raises an error flag. In that case the block substitutes the mean-value (DC) prediction, which is computed from whatever neighbours are present. Missing above-right samples do not cause an error: the block fills them with the last sample directly above.

The start interface follows valid/ready rules. `start_ready` is low only while reset is asserted. An accept happens in any cycle where `start_valid` and `start_ready` are both high. Back-pressure therefore never lasts past reset, and the caller may issue a new start in every cycle. Each result stays on the outputs until the next accept.

Top module: `intra4x4_pred`

## Requirements
- R1: `start_ready` is 0 while `rst_n` is low and 1 in every cycle after reset. A cycle with `start_valid` and `start_ready` both high is an accept. In the cycle after an accept, `pred_rows` and `mode_err` show the new result and `pred_done` is 1. `pred_done` is 0 in any cycle that does not follow an accept.
- R2: Reset clears `pred_rows`, `mode_err` and `pred_done` to 0. In a cycle that follows no accept, `pred_rows` and `mode_err` keep their values whatever the other inputs do.
- R3: Sample x (0..3) of row y (0..3) sits at `pred_rows[(4*y+x)*8 +: 8]`, so row 0 is the least significant word and sample 0 is the low byte. Above sample i is `nbr_above[8*i +: 8]` (i = 0..7). Left sample j is `nbr_left[8*j +: 8]`, with j = 0 at the top.
- R4: Code 0 (vertical) sets every row to above[0..3]. Code 1 (horizontal) fills row y with left[y].
- R5: Code 2 (DC) fills all 16 samples with one value, chosen by availability:
  - above and left both available: (sum of above[0..3] + sum of left[0..3] + 4) >> 3;
  - above only: (sum of above[0..3] + 2) >> 2;
  - left only: (sum of left[0..3] + 2) >> 2;
  - neither: 128.
- R6: Two filters are used. The 3-tap filter is (a + 2b + c + 2) >> 2, with b the centre sample. The 2-tap filter is (a + b + 1) >> 1. Both are exact integer arithmetic with no overflow.
- R7: Code 3 (diagonal down-left) and code 7 (vertical-left) use above[0..7]. When `avail_above_right` is 0, above[4..7] are replaced by above[3]. Diagonal down-left gives f3(above[x+y], above[x+y+1], above[x+y+2]), except at (3,3), where it gives f3(above[6], above[7], above[7]). Vertical-left uses k = x + (y>>1): rows 0 and 2 give f2(above[k], above[k+1]); rows 1 and 3 give f3(above[k], above[k+1], above[k+2]).
- R8: Code 4 (diagonal down-right), code 5 (vertical-right) and code 6 (horizontal-down) filter along the edge left[3], left[2], left[1], left[0], corner, above[0], ..., above[3]. Every sample in these modes follows the standard H.264 zVR/zHD formulas.
- R9: Code 8 (horizontal-up) uses only left samples. The bottom row is left[3] repeated, and samples 2 and 3 of row 2 are also left[3]. Sample (1,2) and sample (3,1) are f3(left[2], left[3], left[3]). The other samples follow the 2-tap and 3-tap filters along the left column.
- R10: `mode_err` is 1 after an accept in any of these cases:
  - the code is 9 to 15;
  - the code is 0, 3, 4, 5, 6 or 7 and `avail_above` is 0;
  - the code is 1, 4, 5, 6 or 8 and `avail_left` is 0.
  When `mode_err` is 1, the output is the R5 DC prediction for the given availability.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request to predict with the current inputs |
| start_ready | output | 1 | Block can accept a request |
| pred_mode | input | 4 | Prediction direction code |
| avail_above | input | 1 | Above row samples are present |
| avail_left | input | 1 | Left column samples are present |
| avail_above_right | input | 1 | Above-right samples 4..7 are present |
| nbr_above | input | 64 | Above samples 0..7, sample 0 in the low byte |
| nbr_left | input | 32 | Left samples 0..3, top sample in the low byte |
| nbr_corner | input | 8 | Above-left corner sample |
| pred_rows | output | 128 | Predicted samples, row 0 in the low word |
| pred_done | output | 1 | One-cycle pulse after an accept |
| mode_err | output | 1 | Last accepted request was illegal; DC fallback was output |

## Verification
The in-RTL assertions check the timing rules on every cycle: a done pulse follows exactly the accepted cycles, and the outputs stay frozen between accepts. They also check a few closed-form results whenever those cases occur: vertical copies, the bottom row in horizontal-up, the 128 fill, and the error flag for unknown codes. The filtered directions need a reference model, and so does the full legality matrix. Above-right padding and DC arithmetic at the extremes (all-zero and all-255 neighbours) need one too. These are covered only by the bench scenarios, which sweep every code against every availability combination.

// File: rtl/intra4x4_pkg.sv
package intra4x4_pkg;

  // Prediction direction codes
  typedef enum logic [3:0] {
    M_VERT = 4'd0,
    M_HORZ = 4'd1,
    M_DC   = 4'd2,
    M_DDL  = 4'd3,
    M_DDR  = 4'd4,
    M_VR   = 4'd5,
    M_HD   = 4'd6,
    M_VL   = 4'd7,
    M_HU   = 4'd8
  } ipred_mode_e;

  // Unified edge: [0..3] = left[3..0], [4] = corner, [5..12] = above[0..7]
  localparam int EDGE_N = 13;
  localparam int E_L0   = 3;
  localparam int E_Q    = 4;
  localparam int E_A0   = 5;
  localparam int NUM_CODES = 16;

  // Filter taps for one sample: 3-tap when three=1, otherwise 2-tap on t0,t1
  typedef struct packed {
    logic       three;
    logic [3:0] t0;
    logic [3:0] t1;
    logic [3:0] t2;
  } tap_t;

  // Left index j (-1 = corner), clamped past the bottom sample
  function automatic int lidx(input int j);
    int jj;
    jj = (j > 3) ? 3 : j;
    return E_L0 - jj;
  endfunction

  // Above index i (-1 = corner), clamped past the last sample
  function automatic int aidx(input int i);
    int ii;
    ii = (i > 7) ? 7 : i;
    return E_A0 + ii;
  endfunction

  function automatic tap_t mk2(input int a, input int b);
    tap_t t;
    t.three = 1'b0;
    t.t0 = 4'(a);
    t.t1 = 4'(b);
    t.t2 = 4'(b);
    return t;
  endfunction

  function automatic tap_t mk3(input int a, input int b, input int c);
    tap_t t;
    t.three = 1'b1;
    t.t0 = 4'(a);
    t.t1 = 4'(b);
    t.t2 = 4'(c);
    return t;
  endfunction

  // Elaboration-time tap selection for sample (x,y) under direction m
  function automatic tap_t tap_for(input int m, input int x, input int y);
    int z;
    int k;
    tap_t t;
    t = mk2(0, 0);
    case (m)
      0: t = mk2(aidx(x), aidx(x));
      1: t = mk2(lidx(y), lidx(y));
      3: begin
        if (x == 3 && y == 3) t = mk3(aidx(6), aidx(7), aidx(7));
        else                  t = mk3(aidx(x+y), aidx(x+y+1), aidx(x+y+2));
      end
      4: begin
        k = E_Q + x - y;
        t = mk3(k - 1, k, k + 1);
      end
      5: begin
        z = 2*x - y;
        k = x - (y >> 1);
        if (z >= 0 && (z % 2) == 0) t = mk2(aidx(k-1), aidx(k));
        else if (z > 0)             t = mk3(aidx(k-2), aidx(k-1), aidx(k));
        else if (z == -1)           t = mk3(lidx(0), E_Q, aidx(0));
        else                        t = mk3(lidx(y-1), lidx(y-2), lidx(y-3));
      end
      6: begin
        z = 2*y - x;
        k = y - (x >> 1);
        if (z >= 0 && (z % 2) == 0) t = mk2(lidx(k-1), lidx(k));
        else if (z > 0)             t = mk3(lidx(k-2), lidx(k-1), lidx(k));
        else if (z == -1)           t = mk3(lidx(0), E_Q, aidx(0));
        else                        t = mk3(aidx(x-1), aidx(x-2), aidx(x-3));
      end
      7: begin
        k = x + (y >> 1);
        if ((y % 2) == 0) t = mk2(aidx(k), aidx(k+1));
        else              t = mk3(aidx(k), aidx(k+1), aidx(k+2));
      end
      8: begin
        k = y + (x >> 1);
        if ((x % 2) == 0) t = mk2(lidx(k), lidx(k+1));
        else              t = mk3(lidx(k), lidx(k+1), lidx(k+2));
      end
      default: t = mk2(0, 0);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/intra4x4_edge.sv
module intra4x4_edge
  import intra4x4_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic [8*PIX_W-1:0]             above_i,
  input  logic [4*PIX_W-1:0]             left_i,
  input  logic [PIX_W-1:0]               corner_i,
  input  logic                           ar_avail_i,
  output logic [EDGE_N-1:0][PIX_W-1:0]   edge_o
);

  // Left column, reversed so the edge runs bottom-left to top-right
  for (genvar j = 0; j < 4; j++) begin : g_left
    assign edge_o[E_L0 - j] = left_i[j*PIX_W +: PIX_W];
  end

  assign edge_o[E_Q] = corner_i;

  for (genvar i = 0; i < 8; i++) begin : g_above
    if (i < 4) begin : g_near
      assign edge_o[E_A0 + i] = above_i[i*PIX_W +: PIX_W];
    end else begin : g_far
      // R7: substitute above[3] for missing above-right samples
      assign edge_o[E_A0 + i] = ar_avail_i ? above_i[i*PIX_W +: PIX_W]
                                           : above_i[3*PIX_W +: PIX_W];
    end
  end

endmodule

// File: rtl/intra4x4_dc.sv
module intra4x4_dc #(
  parameter int PIX_W = 8
) (
  input  logic [4*PIX_W-1:0] above_i,
  input  logic [4*PIX_W-1:0] left_i,
  input  logic               avail_a_i,
  input  logic               avail_l_i,
  output logic [PIX_W-1:0]   dc_o
);

  localparam int SUM4_W = PIX_W + 2;
  localparam int SUM8_W = PIX_W + 3;
  localparam logic [PIX_W-1:0] MID = PIX_W'(1) << (PIX_W - 1);

  logic [SUM4_W-1:0] sum_a;
  logic [SUM4_W-1:0] sum_l;
  logic [SUM8_W-1:0] both_r;
  logic [SUM4_W-1:0] a_r;
  logic [SUM4_W-1:0] l_r;

  always_comb begin
    sum_a = '0;
    sum_l = '0;
    for (int i = 0; i < 4; i++) begin
      sum_a = sum_a + SUM4_W'(above_i[i*PIX_W +: PIX_W]);
      sum_l = sum_l + SUM4_W'(left_i[i*PIX_W +: PIX_W]);
    end
    both_r = SUM8_W'(sum_a) + SUM8_W'(sum_l) + SUM8_W'(4);
    a_r    = sum_a + SUM4_W'(2);
    l_r    = sum_l + SUM4_W'(2);
  end

  // R5: mean over whichever neighbour sets are present
  always_comb begin
    case ({avail_a_i, avail_l_i})
      2'b11:   dc_o = both_r[SUM8_W-1:3];
      2'b10:   dc_o = a_r[SUM4_W-1:2];
      2'b01:   dc_o = l_r[SUM4_W-1:2];
      default: dc_o = MID;
    endcase
  end

endmodule

// File: rtl/intra4x4_dir.sv
module intra4x4_dir
  import intra4x4_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic [EDGE_N-1:0][PIX_W-1:0] edge_i,
  input  logic [3:0]                   mode_i,
  input  logic [PIX_W-1:0]             dc_i,
  output logic [15:0][PIX_W-1:0]       pred_o
);

  localparam int S3_W = PIX_W + 2;
  localparam int S2_W = PIX_W + 1;

  for (genvar y = 0; y < 4; y++) begin : g_row
    for (genvar x = 0; x < 4; x++) begin : g_col
      logic [PIX_W-1:0] cand [NUM_CODES];

      for (genvar m = 0; m < NUM_CODES; m++) begin : g_mode
        if (m == 2 || m > 8) begin : g_dc
          assign cand[m] = dc_i;
        end else begin : g_filt
          localparam tap_t T = tap_for(m, x, y);
          if (T.three) begin : g_f3
            logic [S3_W-1:0] s3;
            // R6: (a + 2b + c + 2) >> 2
            assign s3 = S3_W'(edge_i[T.t0]) + {1'b0, edge_i[T.t1], 1'b0}
                      + S3_W'(edge_i[T.t2]) + S3_W'(2);
            assign cand[m] = s3[S3_W-1:2];
          end else begin : g_f2
            logic [S2_W-1:0] s2;
            // R6: (a + b + 1) >> 1
            assign s2 = S2_W'(edge_i[T.t0]) + S2_W'(edge_i[T.t1]) + S2_W'(1);
            assign cand[m] = s2[S2_W-1:1];
          end
        end
      end

      assign pred_o[4*y + x] = cand[mode_i];
    end
  end

endmodule

// File: rtl/intra4x4_pred.sv
module intra4x4_pred
  import intra4x4_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_valid,
  output logic                  start_ready,
  input  logic [3:0]            pred_mode,
  input  logic                  avail_above,
  input  logic                  avail_left,
  input  logic                  avail_above_right,
  input  logic [8*PIX_W-1:0]    nbr_above,
  input  logic [4*PIX_W-1:0]    nbr_left,
  input  logic [PIX_W-1:0]      nbr_corner,
  output logic [16*PIX_W-1:0]   pred_rows,
  output logic                  pred_done,
  output logic                  mode_err
);

  localparam int ROW_W = 4 * PIX_W;
  localparam logic [PIX_W-1:0] MID = PIX_W'(1) << (PIX_W - 1);

  logic                         accept;
  logic                         need_a;
  logic                         need_l;
  logic                         illegal;
  logic [3:0]                   eff_mode;
  logic [EDGE_N-1:0][PIX_W-1:0] edge_w;
  logic [PIX_W-1:0]             dc_w;
  logic [15:0][PIX_W-1:0]       pred_w;
  logic                         rdy_q;
  logic [16*PIX_W-1:0]          rows_q;
  logic                         done_q;
  logic                         err_q;

  assign accept = start_valid && start_ready;

  // R10: which neighbour sets each direction reads
  always_comb begin
    need_a = 1'b0;
    need_l = 1'b0;
    case (pred_mode)
      M_VERT, M_DDL, M_VL: need_a = 1'b1;
      M_HORZ, M_HU:        need_l = 1'b1;
      M_DDR, M_VR, M_HD: begin
        need_a = 1'b1;
        need_l = 1'b1;
      end
      default: ;
    endcase
    illegal  = (pred_mode > 4'(M_HU)) || (need_a && !avail_above)
            || (need_l && !avail_left);
    eff_mode = illegal ? 4'(M_DC) : pred_mode;
  end

  intra4x4_edge #(.PIX_W(PIX_W)) u_edge (
    .above_i    (nbr_above),
    .left_i     (nbr_left),
    .corner_i   (nbr_corner),
    .ar_avail_i (avail_above_right),
    .edge_o     (edge_w)
  );

  intra4x4_dc #(.PIX_W(PIX_W)) u_dc (
    .above_i   (nbr_above[ROW_W-1:0]),
    .left_i    (nbr_left),
    .avail_a_i (avail_above),
    .avail_l_i (avail_left),
    .dc_o      (dc_w)
  );

  intra4x4_dir #(.PIX_W(PIX_W)) u_dir (
    .edge_i (edge_w),
    .mode_i (eff_mode),
    .dc_i   (dc_w),
    .pred_o (pred_w)
  );

  // R1 / R2: result registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      rows_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      rdy_q  <= 1'b1;
      done_q <= accept;
      if (accept) begin
        rows_q <= pred_w;
        err_q  <= illegal;
      end
    end
  end

  assign start_ready = rdy_q;
  assign pred_rows   = rows_q;
  assign pred_done   = done_q;
  assign mode_err    = err_q;

  // Assertions
  a_r1_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pred_done);

  a_r1_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !pred_done);

  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(pred_rows) && $stable(mode_err)));

  a_r4_vertical_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pred_mode == 4'(M_VERT) && avail_above)
      |=> (pred_rows[ROW_W-1:0] == $past(nbr_above[ROW_W-1:0]))
       && (pred_rows[16*PIX_W-1 -: ROW_W] == $past(nbr_above[ROW_W-1:0])));

  a_r5_dc_none: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pred_mode == 4'(M_DC) && !avail_above && !avail_left)
      |=> (pred_rows == {16{MID}}));

  a_r9_hu_bottom_row: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pred_mode == 4'(M_HU) && avail_left)
      |=> (pred_rows[16*PIX_W-1 -: ROW_W] == {4{$past(nbr_left[ROW_W-1 -: PIX_W])}}));

  a_r10_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pred_mode > 4'(M_HU)) |=> mode_err);

endmodule

// File: tb/intra4x4_pred_tb.sv
module intra4x4_pred_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_valid;
  logic         start_ready;
  logic [3:0]   pred_mode;
  logic         avail_above;
  logic         avail_left;
  logic         avail_above_right;
  logic [63:0]  nbr_above;
  logic [31:0]  nbr_left;
  logic [7:0]   nbr_corner;
  logic [127:0] pred_rows;
  logic         pred_done;
  logic         mode_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [127:0] exp_rows = '0;
  logic         exp_done = 1'b0;
  logic         exp_err  = 1'b0;

  int rA [8];
  int rL [4];
  int rQ;

  always #5 clk = ~clk;

  intra4x4_pred dut_i (
    .clk (clk), .rst_n (rst_n),
    .start_valid (start_valid), .start_ready (start_ready),
    .pred_mode (pred_mode), .avail_above (avail_above),
    .avail_left (avail_left), .avail_above_right (avail_above_right),
    .nbr_above (nbr_above), .nbr_left (nbr_left), .nbr_corner (nbr_corner),
    .pred_rows (pred_rows), .pred_done (pred_done), .mode_err (mode_err)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int P(input int i, input int j);
    if (j < 0) return (i < 0) ? rQ : rA[i];
    return rL[j];
  endfunction

  function automatic int f2(input int a, input int b);
    return (a + b + 1) >> 1;
  endfunction

  function automatic int f3(input int a, input int b, input int c);
    return (a + 2*b + c + 2) >> 2;
  endfunction

  // Behavioural reference, written from the requirement formulas
  function automatic int ref_px(input int m, input int x, input int y);
    int z;
    case (m)
      0: return P(x, -1);
      1: return P(-1, y);
      3: begin
        if (x == 3 && y == 3) return f3(P(6,-1), P(7,-1), P(7,-1));
        return f3(P(x+y,-1), P(x+y+1,-1), P(x+y+2,-1));
      end
      4: begin
        if (x > y) return f3(P(x-y-2,-1), P(x-y-1,-1), P(x-y,-1));
        if (x < y) return f3(P(-1,y-x-2), P(-1,y-x-1), P(-1,y-x));
        return f3(P(0,-1), P(-1,-1), P(-1,0));
      end
      5: begin
        z = 2*x - y;
        if (z >= 0 && z % 2 == 0) return f2(P(x-(y>>1)-1,-1), P(x-(y>>1),-1));
        if (z > 0) return f3(P(x-(y>>1)-2,-1), P(x-(y>>1)-1,-1), P(x-(y>>1),-1));
        if (z == -1) return f3(P(-1,0), P(-1,-1), P(0,-1));
        return f3(P(-1,y-1), P(-1,y-2), P(-1,y-3));
      end
      6: begin
        z = 2*y - x;
        if (z >= 0 && z % 2 == 0) return f2(P(-1,y-(x>>1)-1), P(-1,y-(x>>1)));
        if (z > 0) return f3(P(-1,y-(x>>1)-2), P(-1,y-(x>>1)-1), P(-1,y-(x>>1)));
        if (z == -1) return f3(P(-1,0), P(-1,-1), P(0,-1));
        return f3(P(x-1,-1), P(x-2,-1), P(x-3,-1));
      end
      7: begin
        if (y % 2 == 0) return f2(P(x+(y>>1),-1), P(x+(y>>1)+1,-1));
        return f3(P(x+(y>>1),-1), P(x+(y>>1)+1,-1), P(x+(y>>1)+2,-1));
      end
      8: begin
        z = x + 2*y;
        if (z > 5) return rL[3];
        if (z == 5) return f3(rL[2], rL[3], rL[3]);
        if (z % 2 == 0) return f2(P(-1,y+(x>>1)), P(-1,y+(x>>1)+1));
        return f3(P(-1,y+(x>>1)), P(-1,y+(x>>1)+1), P(-1,y+(x>>1)+2));
      end
      default: return 0;
    endcase
  endfunction

  function automatic string tag_for(input int m, input bit e);
    if (e) return "R10";
    case (m)
      0, 1:    return "R4 (R3 layout)";
      2:       return "R5";
      3, 7:    return "R7 (R6 filters)";
      4, 5, 6: return "R8 (R6 filters)";
      default: return "R9 (R6 filters)";
    endcase
  endfunction

  string cur_tag = "R2";

  task automatic compute_next(output logic [127:0] nr, output logic ne);
    int sa, sl, dcv, m, em, v;
    bit na, nl;
    for (int i = 0; i < 8; i++) rA[i] = int'(nbr_above[8*i +: 8]);
    if (!avail_above_right) for (int i = 4; i < 8; i++) rA[i] = rA[3];
    for (int j = 0; j < 4; j++) rL[j] = int'(nbr_left[8*j +: 8]);
    rQ = int'(nbr_corner);
    m  = int'(pred_mode);
    na = (m == 0 || m == 3 || m == 4 || m == 5 || m == 6 || m == 7);
    nl = (m == 1 || m == 4 || m == 5 || m == 6 || m == 8);
    ne = (m > 8) || (na && !avail_above) || (nl && !avail_left);
    em = ne ? 2 : m;
    sa = rA[0] + rA[1] + rA[2] + rA[3];
    if (!avail_above_right) sa = int'(nbr_above[7:0]) + int'(nbr_above[15:8])
                               + int'(nbr_above[23:16]) + int'(nbr_above[31:24]);
    sl = rL[0] + rL[1] + rL[2] + rL[3];
    if (avail_above && avail_left) dcv = (sa + sl + 4) >> 3;
    else if (avail_above)          dcv = (sa + 2) >> 2;
    else if (avail_left)           dcv = (sl + 2) >> 2;
    else                           dcv = 128;
    for (int y = 0; y < 4; y++)
      for (int x = 0; x < 4; x++) begin
        v = (em == 2) ? dcv : ref_px(em, x, y);
        nr[(4*y + x)*8 +: 8] = 8'(v);
      end
    cur_tag = tag_for(em, ne);
  endtask

  // One cycle: drive at negedge, model updates at posedge, compare at next negedge
  task automatic step(input bit v);
    logic [127:0] nr;
    logic ne;
    nr = '0;
    ne = 1'b0;
    start_valid = v;
    if (v) compute_next(nr, ne);
    @(posedge clk);
    if (v) begin
      exp_rows = nr;
      exp_err  = ne;
      exp_done = 1'b1;
    end else begin
      exp_done = 1'b0;
      cur_tag  = "R2 hold";
    end
    @(negedge clk);
    start_valid = 1'b0;
    chk("R1 done", {127'd0, pred_done}, {127'd0, exp_done});
    chk({cur_tag, " err"}, {127'd0, mode_err}, {127'd0, exp_err});
    chk(cur_tag, pred_rows, exp_rows);
  endtask

  task automatic scramble();
    nbr_above  = {$urandom(), $urandom()};
    nbr_left   = $urandom();
    nbr_corner = 8'($urandom());
    pred_mode  = 4'($urandom());
    avail_above = 1'($urandom());
    avail_left  = 1'($urandom());
    avail_above_right = 1'($urandom());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1 act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start_valid = 1'b0;
    scramble();
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {127'd0, start_ready}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {127'd0, start_ready}, 128'd1);
    chk("R2 reset rows", pred_rows, 128'd0);
    chk("R2 reset flags", {126'd0, pred_done, mode_err}, 128'd0);

    for (int m = 0; m < 16; m++)
      for (int av = 0; av < 8; av++)
        for (int p = 0; p < 4; p++) begin
          pred_mode         = 4'(m);
          avail_above       = av[0];
          avail_left        = av[1];
          avail_above_right = av[2];
          if (p == 0) begin
            nbr_above = '1; nbr_left = '1; nbr_corner = '1;
          end else if (p == 1) begin
            nbr_above = '0; nbr_left = '0; nbr_corner = '0;
          end else begin
            nbr_above  = {$urandom(), $urandom()};
            nbr_left   = $urandom();
            nbr_corner = 8'($urandom());
          end
          step(1'b1);
          if (p % 2 == 1) begin
            // R2: inputs change with no start; outputs must hold
            scramble();
            step(1'b0);
          end
        end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule